// File: doc/BRIEF.md
# Virtio Doorbell, Interrupt Status and Device Window Decoder

This block decodes the part of a virtio device's register aperture that lies past the common configuration structure. Three regions sit back to back: a 4-byte notify doorbell at offsets 56 to 59, a 4-byte interrupt status register (ISR) at offsets 60 to 63, and a device-specific configuration window from offset 64 up to offset 255. Each region starts on a 4-byte boundary. A bus agent issues one access per cycle (offset, direction, write data). The block answers one cycle later with a response strobe, an error flag and read data.

A doorbell write produces a one-cycle queue-notify pulse that carries the 16-bit queue index taken from the write data. All queues share this single register, which corresponds to a notification multiplier of zero. Two interrupt sources set ISR bits, and a legacy level interrupt stays high while any bit is pending. Reading the ISR returns the pending bits, clears them and lets the legacy line fall. Device-window accesses go out on a side port with the offset rebased to the window start, and the read data that comes back is used as the response. Doorbell reads, ISR writes, ISR reads that miss the first byte, and offsets outside the three regions all complete with an error and change nothing.

Top module: `vdb_window`

## Requirements
- R1: After reset, rsp_valid, ntf_valid and irq_legacy are low, and an ISR read returns 0.
- R2: Each cycle with req_valid high yields rsp_valid high in the following cycle. A cycle without a request yields rsp_valid low in the following cycle.
- R3: A write to any offset from 56 to 59 raises ntf_valid for exactly one cycle, in the cycle after the request. ntf_queue equals req_wdata[15:0], and rsp_err is 0.
- R4: A read of offsets 56 to 59 responds with rsp_err = 1, and no notify pulse follows.
- R5: src_queue_irq sets ISR bit 0 and src_cfg_irq sets ISR bit 1. Both bits are sticky. irq_legacy is high from the cycle after a set, and stays high while any bit is pending.
- R6: A read at offset 60 responds with rsp_err = 0 and rsp_rdata = {24'b0, ISR as it stood before the read}. It then clears the ISR, so irq_legacy is low in the cycle after the request unless a new set arrived.
- R7: When a set input and an ISR read fall in the same cycle, the newly set bit remains pending after the clear. The read returns the older value.
- R8: An ISR write, or an ISR read at offset 61, 62 or 63, responds with rsp_err = 1 and leaves the ISR and irq_legacy unchanged.
- R9: An access at offset 64 to 255 drives dev_valid in the same cycle, with dev_off = offset - 64, dev_write = req_write and dev_wdata = req_wdata. The response has rsp_err = 0. A read returns the dev_rdata value presented in that cycle.
- R10: Offsets below 56 or at 256 and above respond with rsp_err = 1. They raise no dev_valid, no notify pulse and no ISR change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 12 | Byte offset in the aperture |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Access not accepted |
| rsp_rdata | output | 32 | Read data |
| ntf_valid | output | 1 | Queue-notify pulse |
| ntf_queue | output | 16 | Notified queue index |
| src_queue_irq | input | 1 | Sets ISR bit 0 |
| src_cfg_irq | input | 1 | Sets ISR bit 1 |
| irq_legacy | output | 1 | Level interrupt, high while ISR is nonzero |
| dev_valid | output | 1 | Device-window access strobe |
| dev_write | output | 1 | Device-window direction |
| dev_off | output | 8 | Offset rebased to the device window |
| dev_wdata | output | 32 | Device-window write data |
| dev_rdata | input | 32 | Device-window read data, same cycle |

## Verification
Several properties are checked on every cycle:
- each request is answered exactly one cycle later;
- a notify pulse comes only with an error-free response;
- a set input is still pending in the next cycle even when a clearing read coincides with it;
- the legacy line falls only after an ISR read;
- the device strobe appears only with a request.

Other behaviour can only be shown by the directed scenarios:
- the offset bounds of each region;
- the queue index value carried by the pulse;
- the rebased device offset and the read data returned from the device;
- the value an ISR read returns;
- the absence of side effects after rejected accesses.

// File: rtl/vdb_pkg.sv
package vdb_pkg;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_NOTIFY = 2'd1,
        RGN_ISR    = 2'd2,
        RGN_DEV    = 2'd3
    } region_e;

endpackage

// File: rtl/vdb_decode.sv
module vdb_decode
    import vdb_pkg::*;
#(
    parameter int OFF_W        = 12,
    parameter int NOTIFY_BASE  = 56,
    parameter int REGION_BYTES = 4,
    parameter int WIN_BYTES    = 256,
    parameter int DEV_OFF_W    = 8
) (
    input  logic [OFF_W-1:0]     off_i,
    output region_e              rgn_o,
    output logic                 isr_first_o,
    output logic [DEV_OFF_W-1:0] dev_off_o
);
    localparam int ISR_BASE = NOTIFY_BASE + REGION_BYTES;
    localparam int DEV_BASE = ISR_BASE + REGION_BYTES;
    localparam logic [OFF_W-1:0] NTF_LO = OFF_W'(NOTIFY_BASE);
    localparam logic [OFF_W-1:0] ISR_LO = OFF_W'(ISR_BASE);
    localparam logic [OFF_W-1:0] DEV_LO = OFF_W'(DEV_BASE);
    localparam logic [OFF_W-1:0] WIN_HI = OFF_W'(WIN_BYTES);

    logic [OFF_W-1:0] rebased;

    always_comb begin
        rebased   = off_i - DEV_LO;
        dev_off_o = rebased[DEV_OFF_W-1:0];
        if (off_i < NTF_LO)       rgn_o = RGN_NONE;
        else if (off_i < ISR_LO)  rgn_o = RGN_NOTIFY;
        else if (off_i < DEV_LO)  rgn_o = RGN_ISR;
        else if (off_i < WIN_HI)  rgn_o = RGN_DEV;
        else                      rgn_o = RGN_NONE;
        isr_first_o = (off_i == ISR_LO);
    end
endmodule

// File: rtl/vdb_isr.sv
module vdb_isr #(
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_i,
    input  logic             clr_i,
    output logic [ISR_W-1:0] isr_o,
    output logic             irq_o
);
    logic [ISR_W-1:0] isr_d, isr_q;

    always_comb begin
        isr_d = (clr_i ? '0 : isr_q) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr_o = isr_q;
    assign irq_o = |isr_q;

    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((isr_q & $past(set_i)) == $past(set_i))); // R7
    AST_IRQ_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> irq_o); // R5
    AST_DROP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_i)); // R6
endmodule

// File: rtl/vdb_window.sv
module vdb_window
    import vdb_pkg::*;
#(
    parameter int OFF_W        = 12,
    parameter int DATA_W       = 32,
    parameter int QIDX_W       = 16,
    parameter int NOTIFY_BASE  = 56,
    parameter int REGION_BYTES = 4,
    parameter int WIN_BYTES    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ntf_valid,
    output logic [QIDX_W-1:0] ntf_queue,
    input  logic              src_queue_irq,
    input  logic              src_cfg_irq,
    output logic              irq_legacy,
    output logic              dev_valid,
    output logic              dev_write,
    output logic [7:0]        dev_off,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);
    localparam int ISR_W     = 8;
    localparam int DEV_BASE  = NOTIFY_BASE + 2 * REGION_BYTES;
    localparam int DEV_OFF_W = $clog2(WIN_BYTES - DEV_BASE);

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
        logic              ntf_valid;
        logic [QIDX_W-1:0] ntf_queue;
    } out_t;

    out_t                 out_d, out_q;
    region_e              rgn;
    logic                 isr_first;
    logic [DEV_OFF_W-1:0] rebased_off;
    logic [ISR_W-1:0]     isr_val;
    logic [ISR_W-1:0]     isr_set;
    logic                 isr_clr;

    vdb_decode #(
        .OFF_W(OFF_W), .NOTIFY_BASE(NOTIFY_BASE), .REGION_BYTES(REGION_BYTES),
        .WIN_BYTES(WIN_BYTES), .DEV_OFF_W(DEV_OFF_W)
    ) decode_i (
        .off_i(req_off), .rgn_o(rgn), .isr_first_o(isr_first), .dev_off_o(rebased_off)
    );

    assign isr_set = {{(ISR_W-2){1'b0}}, src_cfg_irq, src_queue_irq};
    assign isr_clr = req_valid && !req_write && (rgn == RGN_ISR) && isr_first;

    vdb_isr #(.ISR_W(ISR_W)) isr_i (
        .clk(clk), .rst_n(rst_n), .set_i(isr_set), .clr_i(isr_clr),
        .isr_o(isr_val), .irq_o(irq_legacy)
    );

    always_comb begin
        out_d = '0;
        out_d.rsp_valid = req_valid;
        out_d.rsp_err   = req_valid;
        if (req_valid) begin
            unique case (rgn)
                RGN_NOTIFY: if (req_write) begin
                    out_d.rsp_err   = 1'b0;
                    out_d.ntf_valid = 1'b1;
                    out_d.ntf_queue = req_wdata[QIDX_W-1:0];
                end
                RGN_ISR: if (isr_clr) begin
                    out_d.rsp_err   = 1'b0;
                    out_d.rsp_rdata = DATA_W'(isr_val);
                end
                RGN_DEV: begin
                    out_d.rsp_err = 1'b0;
                    if (!req_write) out_d.rsp_rdata = dev_rdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid = out_q.rsp_valid;
    assign rsp_err   = out_q.rsp_err;
    assign rsp_rdata = out_q.rsp_rdata;
    assign ntf_valid = out_q.ntf_valid;
    assign ntf_queue = out_q.ntf_queue;

    assign dev_valid = req_valid && (rgn == RGN_DEV);
    assign dev_write = req_write;
    assign dev_off   = 8'(rebased_off);
    assign dev_wdata = req_wdata;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_NTF_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (rsp_valid && !rsp_err)); // R3
    AST_ERR_NO_NTF: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !ntf_valid); // R4
    AST_DEV_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> req_valid); // R9
endmodule

// File: tb/vdb_window_tb.sv
module vdb_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, ntf_valid, irq_legacy;
    logic [31:0] rsp_rdata;
    logic [15:0] ntf_queue;
    logic        src_queue_irq = 1'b0, src_cfg_irq = 1'b0;
    logic        dev_valid, dev_write;
    logic [7:0]  dev_off;
    logic [31:0] dev_wdata, dev_rdata;

    int total = 0;
    int bad = 0;

    logic        s_dev_valid, s_dev_write;
    logic [7:0]  s_dev_off;
    logic [31:0] s_dev_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dev_rdata = {24'hA5C3E1, dev_off};

    vdb_window dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ntf_valid(ntf_valid),
        .ntf_queue(ntf_queue), .src_queue_irq(src_queue_irq),
        .src_cfg_irq(src_cfg_irq), .irq_legacy(irq_legacy),
        .dev_valid(dev_valid), .dev_write(dev_write), .dev_off(dev_off),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample side port mid-cycle, response at next negedge.
    task automatic access(input logic wr, input logic [11:0] off, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = wd;
        #(CLK_PERIOD/4);
        s_dev_valid = dev_valid; s_dev_write = dev_write;
        s_dev_off = dev_off; s_dev_wdata = dev_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse_src(input logic q, input logic c);
        @(negedge clk);
        src_queue_irq = q; src_cfg_irq = c;
        @(negedge clk);
        src_queue_irq = 1'b0; src_cfg_irq = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 ntf_valid", {31'b0, ntf_valid}, 32'd0);
        check("R1 irq_legacy", {31'b0, irq_legacy}, 32'd0);
        access(1'b0, 12'd60, 32'd0);
        check("R1 isr after reset", rsp_rdata, 32'd0);
        check("R2 rsp_valid after req", {31'b0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R2 no rsp when idle", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_notify;
        for (int k = 56; k < 60; k++) begin
            access(1'b1, 12'(k), 32'hBEEF_0000 | 32'(k * 3));
            check("R3 ntf_valid", {31'b0, ntf_valid}, 32'd1);
            check("R3 ntf_queue", {16'b0, ntf_queue}, 32'(k * 3));
            check("R3 rsp_err", {31'b0, rsp_err}, 32'd0);
        end
        @(negedge clk);
        check("R3 single-cycle pulse", {31'b0, ntf_valid}, 32'd0);
        access(1'b0, 12'd57, 32'd0);
        check("R4 read err", {31'b0, rsp_err}, 32'd1);
        check("R4 no pulse", {31'b0, ntf_valid}, 32'd0);
    endtask

    task automatic t_isr;
        pulse_src(1'b1, 1'b0);
        check("R5 irq after queue set", {31'b0, irq_legacy}, 32'd1);
        pulse_src(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 irq sticky", {31'b0, irq_legacy}, 32'd1);
        access(1'b1, 12'd60, 32'hFF);
        check("R8 isr write err", {31'b0, rsp_err}, 32'd1);
        for (int k = 61; k < 64; k++) begin
            access(1'b0, 12'(k), 32'd0);
            check("R8 off-first read err", {31'b0, rsp_err}, 32'd1);
        end
        check("R8 irq kept", {31'b0, irq_legacy}, 32'd1);
        access(1'b0, 12'd60, 32'd0);
        check("R6 isr value", rsp_rdata, 32'h3);
        check("R6 isr read ok", {31'b0, rsp_err}, 32'd0);
        check("R6 irq dropped", {31'b0, irq_legacy}, 32'd0);
        access(1'b0, 12'd60, 32'd0);
        check("R6 cleared", rsp_rdata, 32'd0);
    endtask

    task automatic t_race;
        pulse_src(1'b0, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = 12'd60; src_queue_irq = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; src_queue_irq = 1'b0;
        check("R7 read sees old", rsp_rdata, 32'h2);
        check("R7 irq still high", {31'b0, irq_legacy}, 32'd1);
        access(1'b0, 12'd60, 32'd0);
        check("R7 new bit survived", rsp_rdata, 32'h1);
    endtask

    task automatic t_dev;
        access(1'b1, 12'd64, 32'h1234_5678);
        check("R9 dev_valid", {31'b0, s_dev_valid}, 32'd1);
        check("R9 dev_off lo", {24'b0, s_dev_off}, 32'd0);
        check("R9 dev_write", {31'b0, s_dev_write}, 32'd1);
        check("R9 dev_wdata", s_dev_wdata, 32'h1234_5678);
        check("R9 write ok", {31'b0, rsp_err}, 32'd0);
        access(1'b0, 12'd255, 32'd0);
        check("R9 dev_off hi", {24'b0, s_dev_off}, 32'd191);
        check("R9 dev_write rd", {31'b0, s_dev_write}, 32'd0);
        check("R9 read data", rsp_rdata, 32'hA5C3_E1BF);
    endtask

    task automatic t_outside;
        pulse_src(1'b1, 1'b0);
        access(1'b1, 12'd256, 32'h7);
        check("R10 256 err", {31'b0, rsp_err}, 32'd1);
        check("R10 256 no dev", {31'b0, s_dev_valid}, 32'd0);
        check("R10 256 no ntf", {31'b0, ntf_valid}, 32'd0);
        access(1'b0, 12'd60 | 12'h100, 32'd0);
        check("R10 alias err", {31'b0, rsp_err}, 32'd1);
        access(1'b1, 12'd20, 32'h9);
        check("R10 low err", {31'b0, rsp_err}, 32'd1);
        check("R10 low no dev", {31'b0, s_dev_valid}, 32'd0);
        check("R10 low no ntf", {31'b0, ntf_valid}, 32'd0);
        access(1'b0, 12'd60, 32'd0);
        check("R10 isr untouched", rsp_rdata, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_notify();
        t_isr();
        t_race();
        t_dev();
        t_outside();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule